// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer on a simple 32-bit register bus. It also holds a free-running timebase that software can read. The watchdog counts only while two enable bits, one in each of two control words, are both set. A run of 2^N enabled clock cycles with no service is one interval. The first interval that expires raises a flag and a level interrupt. If a second interval expires while that flag is still set, the block sends a reset request pulse of fixed length to the system and records a sticky reset-status flag.

Software keeps the watchdog alive by writing ones to the flag bits. This clears the flags it writes and starts the interval counter again from zero. A build option locks the enables: once both are set, writes that would clear them are ignored, and only a block reset releases the lock. The bus is one cycle: writes take effect on the clock edge, and read data follows the address combinationally.

Top module: `twostage_wdt`

## Requirements
- R1: After a synchronous reset, every register reads 0, the timebase restarts from 0, and `irq` and `sys_rst_req` are low.
- R2: Control word A is at offset 0x0. Its bit 3 is the reset-status flag, bit 2 the expiry flag, bit 1 enable A, and bit 0 a read-only mirror of enable B. Control word B is at offset 0x4, with enable B at bit 0. The timebase reads at offset 0x8. All other bits read 0.
- R3: The interval counter advances only while both enables are set. When either enable is clear, the counter is held at zero, so an interval starts fresh when the watchdog is enabled again.
- R4: A write to offset 0x0 with bit 2 or bit 3 set clears each flag written as 1 and restarts the interval from zero. This write takes priority over an expiry in the same cycle.
- R5: An interval expires after 2^N consecutive enabled cycles. The first expiry sets the expiry flag, and `irq` equals that flag.
- R6: An expiry while the expiry flag is already set starts a reset pulse and sets the reset-status flag. With no service, this happens 2 × 2^N enabled cycles after enabling.
- R7: The timebase at offset 0x8 increments by one on every clock edge outside reset.
- R8: With ENABLE_ONCE = 1, once both enables are set, writes of 0 to either enable bit are ignored until block reset. With ENABLE_ONCE = 0, either enable can be cleared.
- R9: `sys_rst_req` stays high for exactly RST_PULSE_CYCLES cycles. The reset-status flag stays set afterwards until software writes 1 to it.
- R10: Reads of unmapped offsets return 0. Writes to offset 0x8 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, high while the expiry flag is set |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with N = 4, so one interval is 16 cycles. At that size a first expiry, a second expiry, the full reset pulse, and a third expiry that retriggers the pulse all happen within a few dozen cycles. RST_PULSE_CYCLES = 3 lets the bench count the exact pulse length. Two instances run side by side on the same stimulus, one with ENABLE_ONCE = 0 and one with ENABLE_ONCE = 1. The same attempts to clear the enables therefore take effect on one instance and are ignored by the other.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  localparam int OFS_CTLA = 'h0;
  localparam int OFS_CTLB = 'h4;
  localparam int OFS_TBASE = 'h8;

  localparam int BIT_RSTSTAT = 3;
  localparam int BIT_EXPIRED = 2;
  localparam int BIT_ENA = 1;
  localparam int BIT_ENB = 0;

  function automatic logic [31:0] pack_ctla(input logic rstat, input logic expd,
                                            input logic ena, input logic enb);
    logic [31:0] w;
    w = '0;
    w[BIT_RSTSTAT] = rstat;
    w[BIT_EXPIRED] = expd;
    w[BIT_ENA] = ena;
    w[BIT_ENB] = enb;
    return w;
  endfunction

  function automatic logic [31:0] pack_ctlb(input logic enb);
    logic [31:0] w;
    w = '0;
    w[BIT_ENB] = enb;
    return w;
  endfunction
endpackage

// File: rtl/twostage_wdt_timebase.sv
module twostage_wdt_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] tb_o
);
  logic [W-1:0] tb_q;

  always_ff @(posedge clk) begin
    if (rst) tb_q <= '0;
    else     tb_q <= tb_q + 1'b1;
  end

  assign tb_o = tb_q;

  assert_timebase_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tb_q == $past(tb_q) + 1'b1);
endmodule

// File: rtl/twostage_wdt_interval.sv
module twostage_wdt_interval #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);
  logic [N-1:0] cnt_q;
  logic         at_end;

  assign at_end = &cnt_q;
  assign expire = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
  assert_restart_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expire);
endmodule

// File: rtl/twostage_wdt_pulse.sv
module twostage_wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  output logic pulse_o
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (trip)          left_q <= PW'(LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  assert_pulse_after_trip_R6: assert property (@(posedge clk) disable iff (rst)
    trip |=> pulse_o);
endmodule

// File: rtl/twostage_wdt_regs.sv
module twostage_wdt_regs #(
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctla,
  input  logic       wr_ctlb,
  input  logic [3:0] wbits,
  input  logic       expire,
  output logic       en_a,
  output logic       en_b,
  output logic       expired,
  output logic       rstat,
  output logic       restart,
  output logic       active,
  output logic       trip
);
  import twostage_wdt_pkg::*;

  logic en_a_q, en_b_q, expd_q, rstat_q;
  logic locked, clr_expd, clr_rstat;

  assign active    = en_a_q && en_b_q;
  assign locked    = ENABLE_ONCE && active;
  assign clr_expd  = wr_ctla && wbits[BIT_EXPIRED];
  assign clr_rstat = wr_ctla && wbits[BIT_RSTSTAT];
  assign restart   = clr_expd || clr_rstat;
  assign trip      = expire && expd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      expd_q  <= 1'b0;
      rstat_q <= 1'b0;
    end else begin
      if (wr_ctla && (wbits[BIT_ENA] || !locked)) en_a_q <= wbits[BIT_ENA];
      if (wr_ctlb && (wbits[BIT_ENB] || !locked)) en_b_q <= wbits[BIT_ENB];
      if (clr_expd)    expd_q <= 1'b0;
      else if (expire) expd_q <= 1'b1;
      if (clr_rstat)   rstat_q <= 1'b0;
      else if (trip)   rstat_q <= 1'b1;
    end
  end

  assign en_a    = en_a_q;
  assign en_b    = en_b_q;
  assign expired = expd_q;
  assign rstat   = rstat_q;

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> (en_a_q && en_b_q));
  assert_keepalive_clears_R4: assert property (@(posedge clk) disable iff (rst)
    clr_expd |=> !expd_q);
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
  parameter int N                = 16,
  parameter int RST_PULSE_CYCLES = 16,
  parameter bit ENABLE_ONCE      = 1'b0,
  parameter int ADDR_W           = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  import twostage_wdt_pkg::*;

  logic sel_a, sel_b, sel_t;
  logic en_a, en_b, expired, rstat, restart, active, trip, expire;
  logic [31:0] tb;
  logic unused_wdata_hi;

  assign sel_a = (bus_addr == ADDR_W'(OFS_CTLA));
  assign sel_b = (bus_addr == ADDR_W'(OFS_CTLB));
  assign sel_t = (bus_addr == ADDR_W'(OFS_TBASE));
  assign unused_wdata_hi = ^bus_wdata[31:4];

  twostage_wdt_regs #(.ENABLE_ONCE(ENABLE_ONCE)) regs_i (
    .clk(clk), .rst(rst),
    .wr_ctla(bus_wr && sel_a), .wr_ctlb(bus_wr && sel_b),
    .wbits(bus_wdata[3:0]), .expire(expire),
    .en_a(en_a), .en_b(en_b), .expired(expired), .rstat(rstat),
    .restart(restart), .active(active), .trip(trip)
  );

  twostage_wdt_interval #(.N(N)) ivl_i (
    .clk(clk), .rst(rst), .run(active), .restart(restart), .expire(expire)
  );

  twostage_wdt_pulse #(.LEN(RST_PULSE_CYCLES)) pulse_i (
    .clk(clk), .rst(rst), .trip(trip), .pulse_o(sys_rst_req)
  );

  twostage_wdt_timebase #(.W(32)) tb_i (
    .clk(clk), .rst(rst), .tb_o(tb)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_a)      bus_rdata = pack_ctla(rstat, expired, en_a, en_b);
    else if (sel_b) bus_rdata = pack_ctlb(en_b);
    else if (sel_t) bus_rdata = tb;
  end

  assign irq = expired;

  assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> rstat);
  assert_reset_needs_irq_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> $past(irq));
endmodule

// File: tb/twostage_wdt_tb_top.sv
module twostage_wdt_tb_top;
  localparam int NL = 4;
  localparam int PULSE = 3;
  localparam int IVL = 1 << NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_w [2];
  logic irq_w [2];
  logic rreq_w [2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  twostage_wdt #(.N(NL), .RST_PULSE_CYCLES(PULSE), .ENABLE_ONCE(1'b0), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_w[0]), .irq(irq_w[0]), .sys_rst_req(rreq_w[0]));

  twostage_wdt #(.N(NL), .RST_PULSE_CYCLES(PULSE), .ENABLE_ONCE(1'b1), .ADDR_W(4)) dut_lock_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_w[1]), .irq(irq_w[1]), .sys_rst_req(rreq_w[1]));

  // behavioural reference model, one slot per instance (slot 1 has the enable lock)
  bit m_ena [2], m_enb [2], m_exp [2], m_rst [2];
  int m_cnt [2], m_pul [2];
  logic [31:0] m_tb;

  function automatic logic [31:0] model_read(int i, logic [3:0] a);
    case (a)
      4'h0: return {28'd0, m_rst[i], m_exp[i], m_ena[i], m_enb[i]};
      4'h4: return {31'd0, m_enb[i]};
      4'h8: return m_tb;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    live = 1;
    if (rst) begin
      m_tb = 0;
      for (int i = 0; i < 2; i++) begin
        m_ena[i] = 0; m_enb[i] = 0; m_exp[i] = 0; m_rst[i] = 0; m_cnt[i] = 0; m_pul[i] = 0;
      end
    end else begin
      m_tb = m_tb + 1;
      for (int i = 0; i < 2; i++) begin
        bit run, keep, fire, lockd, n_ena, n_enb, n_exp, n_rst;
        int n_cnt, n_pul;
        run = m_ena[i] && m_enb[i];
        lockd = (i == 1) && run;
        keep = bus_wr && bus_addr == 4'h0 && (bus_wdata[2] || bus_wdata[3]);
        fire = run && !keep && (m_cnt[i] == IVL - 1);
        n_cnt = (!run || keep) ? 0 : (m_cnt[i] + 1) % IVL;
        n_exp = m_exp[i]; n_rst = m_rst[i];
        n_pul = (m_pul[i] > 0) ? m_pul[i] - 1 : 0;
        if (fire && m_exp[i]) begin n_rst = 1; n_pul = PULSE; end
        if (fire) n_exp = 1;
        if (keep && bus_wdata[2]) n_exp = 0;
        if (keep && bus_wdata[3]) n_rst = 0;
        n_ena = m_ena[i]; n_enb = m_enb[i];
        if (bus_wr && bus_addr == 4'h0 && !(lockd && !bus_wdata[1])) n_ena = bus_wdata[1];
        if (bus_wr && bus_addr == 4'h4 && !(lockd && !bus_wdata[0])) n_enb = bus_wdata[0];
        m_ena[i] = n_ena; m_enb[i] = n_enb; m_exp[i] = n_exp; m_rst[i] = n_rst;
        m_cnt[i] = n_cnt; m_pul[i] = n_pul;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      for (int i = 0; i < 2; i++) begin
        logic [31:0] e;
        string tg;
        e = model_read(i, bus_addr);
        case (bus_addr)
          4'h0, 4'h4: tg = "R2 ctl";
          4'h8: tg = "R7 timebase";
          default: tg = "R10 unmapped";
        endcase
        chk(rdata_w[i] === e, tg, rdata_w[i], e);
        chk(irq_w[i] === m_exp[i], "R5 irq", {31'd0, irq_w[i]}, {31'd0, m_exp[i]});
        chk(rreq_w[i] === (m_pul[i] > 0), "R6 sys_rst_req", {31'd0, rreq_w[i]},
            {31'd0, m_pul[i] > 0});
      end
    end
  end

  task automatic cyc(logic [3:0] a, bit w, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = w; bus_wdata = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(4'(k * 4), 0, 0);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v0, output logic [31:0] v1);
    cyc(a, 0, 0);
    @(negedge clk);
    v0 = rdata_w[0]; v1 = rdata_w[1];
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1; bus_wr = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    logic [31:0] a0, a1, b0, b1;
    int pc0, pc1;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    rd(4'h0, a0, a1);
    chk(a0 == 0 && a1 == 0, "R1 ctl word after reset", a0 | a1, 0);
    chk(!irq_w[0] && !rreq_w[0], "R1 outputs low", {30'd0, irq_w[0], rreq_w[0]}, 0);
    // R3: one enable only, no counting
    cyc(4'h0, 1, 32'h2);
    idle(40);
    @(negedge clk);
    chk(!irq_w[0] && !irq_w[1], "R3 single enable does not count", {31'd0, irq_w[0]}, 0);
    // R5: both enables, first expiry
    cyc(4'h4, 1, 32'h1);
    idle(IVL + 4);
    @(negedge clk);
    chk(irq_w[0] && irq_w[1], "R5 first expiry raises irq", {31'd0, irq_w[0]}, 1);
    chk(!rreq_w[0], "R5 first expiry no reset", {31'd0, rreq_w[0]}, 0);
    // R4: keepalive clears the flag
    cyc(4'h0, 1, 32'h6);
    cyc(4'h8, 0, 0);
    @(negedge clk);
    chk(!irq_w[0] && !irq_w[1], "R4 keepalive clears irq", {31'd0, irq_w[0]}, 0);
    // R6 / R9: two expiries, count the pulse
    pc0 = 0; pc1 = 0;
    for (int k = 0; k < 2 * IVL + 8; k++) begin
      cyc(4'(k * 4), 0, 0);
      @(negedge clk);
      pc0 += rreq_w[0]; pc1 += rreq_w[1];
    end
    chk(pc0 == PULSE && pc1 == PULSE, "R9 pulse length", pc0, PULSE);
    rd(4'h0, a0, a1);
    chk(a0[3:2] == 2'b11 && a1[3:2] == 2'b11, "R9 reset status sticky", a0, 32'hF);
    // R4: write ones to both flags
    cyc(4'h0, 1, 32'hE);
    rd(4'h0, a0, a1);
    chk(a0[3:2] == 0 && a1[3:2] == 0, "R4 flags cleared", a0, 32'h3);
    // R10: writes to timebase and unmapped offsets
    cyc(4'h8, 1, 32'hFFFF_FFFF);
    cyc(4'hC, 1, 32'hFFFF_FFFF);
    rd(4'hC, a0, a1);
    chk(a0 == 0 && a1 == 0, "R10 unmapped reads zero", a0, 0);
    rd(4'h0, a0, a1);
    chk(a0[3:0] == 4'h3, "R10 ctl untouched by other writes", a0, 32'h3);
    // R7: successive timebase reads
    rd(4'h8, a0, a1);
    rd(4'h8, b0, b1);
    chk(b0 - a0 == 1, "R7 timebase step", b0 - a0, 1);
    // R8: clearing the enables
    cyc(4'h4, 1, 32'h0);
    rd(4'h4, a0, a1);
    chk(a0 == 0, "R8 unlocked enable B clears", a0, 0);
    chk(a1 == 1, "R8 locked enable B held", a1, 1);
    cyc(4'h0, 1, 32'h0);
    rd(4'h0, a0, a1);
    chk(a0[1:0] == 2'b00, "R8 unlocked enable A clears", a0, 0);
    chk(a1[1:0] == 2'b11, "R2 locked mirror and enable A", a1, 3);
    idle(3 * IVL);
    // R1: block reset releases the lock
    do_reset();
    rd(4'h0, a0, a1);
    chk(a1 == 0, "R1 reset releases lock", a1, 0);
    // R3: enable, stop midway, re-enable
    cyc(4'h0, 1, 32'h2);
    cyc(4'h4, 1, 32'h1);
    idle(IVL - 4);
    cyc(4'h4, 1, 32'h0);
    idle(5);
    cyc(4'h4, 1, 32'h1);
    idle(IVL - 4);
    @(negedge clk);
    chk(!irq_w[0], "R3 interval restarts after disable", {31'd0, irq_w[0]}, 0);
    idle(3 * IVL + 6);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule